// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small serial EEPROM behind a chip-select, serial-clock, data-in and data-out pin set. A host raises chip select and clocks in an instruction. The block can return a stored 16-bit word, change one word or all 64 words, or set and clear a programming permission. Storage is a 64 x 16 register array. The programming time of a real cell is modelled by a counter that runs for a set number of system clocks.

The serial pins are not a clock domain of their own. All three inputs pass through a synchronizer into the system clock, and serial-clock edges are found by comparing successive samples. Data out comes with an output-enable, which is low whenever no output phase is active. While a program cycle runs, the host can drop chip select and raise it again to poll ready/busy on the data pin.

Top module: `mw_eeprom`

## Requirements
- R1: After a rising edge of chip select, zeros sampled on serial-clock rising edges are skipped. The first 1 is the start bit. It is followed by a 2-bit opcode and a 6-bit address, each sent MSB first. Opcodes: 10 = read, 01 = write, 11 = erase, 00 = extended. For an extended instruction, address bits [5:4] select the form: 11 = enable, 00 = disable, 10 = erase all, 01 = write all.
- R2: A read drives a 0 as soon as the last address bit is taken. Each later serial-clock rising edge then shifts out the next bit of the addressed word, MSB first, 16 bits in total. Data out changes only on those edges.
- R3: Programming permission is off after reset. While it is off, write, erase, erase-all and write-all change no word and start no program cycle.
- R4: The enable form turns programming permission on. It stays on until the disable form runs or reset is applied. Reads give the same result whatever the permission state.
- R5: A write takes 16 data bits, MSB first, and stores them at the address. The program cycle starts on the edge that takes the last data bit.
- R6: Erase sets the addressed word to 16'hFFFF. Erase-all sets every word to 16'hFFFF. Both start the program cycle as soon as the instruction is decoded.
- R7: Write-all takes 16 data bits and stores that pattern in all 64 words.
- R8: Chip select may be taken low and then high while a program cycle runs. The output is then enabled and drives 0 while busy and 1 once the cycle ends. This lasts until chip select goes low again.
- R9: If chip select rises only after the program cycle has ended, no status is shown and the output stays disabled.
- R10: Output-enable is low in reset and within one clock after the synchronized chip select goes low. Every word holds 16'hFFFF after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Chip select, active high, asynchronous to clk |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (read data or ready/busy) |
| sdo_oe_o | output | 1 | Output-enable for sdo_o; low means high-impedance |

## Verification
Each pin edge reaches the state logic three system clocks later: two synchronizer stages plus the edge register. So read bits and the status level appear about three clocks after the serial-clock or chip-select edge that causes them. The bench holds every serial-clock half period and chip-select change for eight clocks. It samples data out at the end of each high phase, where the value has long settled. The ready level is due PROG_CYC clocks after the last data bit, so the bench waits PROG_CYC plus a margin before expecting it. It also waits that long before testing the no-status case.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 6;
    localparam int OPC_W  = 2;
    localparam int CMD_W  = OPC_W + ADDR_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } opc_e;

    typedef enum logic [1:0] {
        EX_LOCK  = 2'b00,
        EX_FILL  = 2'b01,
        EX_CLEAR = 2'b10,
        EX_OPEN  = 2'b11
    } ext_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_CMD, ST_READ, ST_DATA, ST_DONE, ST_STAT
    } st_e;

    typedef struct packed {
        opc_e              opc;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic ext_e ext_of(logic [ADDR_W-1:0] a);
        return ext_e'(a[ADDR_W-1 -: 2]);
    endfunction
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= '0;
            else     stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (start_i)       cnt <= CW'(CYC);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);

    // R5: a new program cycle is only launched when none is running
    a_r5_start_when_idle: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !busy_o);
endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic          all_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int N = 1 << AW;
    logic [DW-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem[i] <= '1;
        end else if (we_i) begin
            if (all_i) begin
                for (int i = 0; i < N; i++) mem[i] <= wdata_i;
            end else begin
                mem[waddr_i] <= wdata_i;
            end
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int PROG_CYC    = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    logic cs_s, sk_s, di_s, cs_d, sk_d;
    logic sk_rise, cs_rise;

    mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .d({sel_i, sclk_i, sdi_i}),
        .q({cs_s, sk_s, di_s})
    );

    assign sk_rise = sk_s & ~sk_d;
    assign cs_rise = cs_s & ~cs_d;

    st_e               st;
    logic [CMD_W-1:0]  cmd_q;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              wen_q;
    logic              dout_q;
    logic              busy;

    cmd_t              cmd_cur, cmd_nx;
    logic [WORD_W-1:0] data_nx;
    logic              cmd_last, data_last;
    logic              prog_we, prog_all;
    logic [WORD_W-1:0] prog_data;
    logic [ADDR_W-1:0] prog_addr;
    logic [WORD_W-1:0] rd_word;

    always_comb begin
        cmd_cur   = cmd_t'(cmd_q);
        cmd_nx    = cmd_t'({cmd_q[CMD_W-2:0], di_s});
        data_nx   = {shreg[WORD_W-2:0], di_s};
        cmd_last  = cs_s && (st == ST_CMD)  && sk_rise && (cnt == CNT_W'(CMD_W-1));
        data_last = cs_s && (st == ST_DATA) && sk_rise && (cnt == CNT_W'(WORD_W-1));
        prog_we   = 1'b0;
        if (wen_q && !busy) begin
            if (data_last)
                prog_we = 1'b1;
            else if (cmd_last && (cmd_nx.opc == OP_ERASE ||
                     (cmd_nx.opc == OP_EXT && ext_of(cmd_nx.addr) == EX_CLEAR)))
                prog_we = 1'b1;
        end
        prog_all  = data_last ? (cmd_cur.opc == OP_EXT) : (cmd_nx.opc == OP_EXT);
        prog_data = data_last ? data_nx : '1;
        prog_addr = data_last ? cmd_cur.addr : cmd_nx.addr;
    end

    mw_array #(.AW(ADDR_W), .DW(WORD_W)) u_array (
        .clk(clk), .rst(rst),
        .we_i(prog_we), .all_i(prog_all),
        .waddr_i(prog_addr), .wdata_i(prog_data),
        .raddr_i(cmd_nx.addr), .rdata_o(rd_word)
    );

    mw_timer #(.CYC(PROG_CYC)) u_timer (
        .clk(clk), .rst(rst), .start_i(prog_we), .busy_o(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cmd_q  <= '0;
            shreg  <= '0;
            cnt    <= '0;
            wen_q  <= 1'b0;
            dout_q <= 1'b0;
            cs_d   <= 1'b0;
            sk_d   <= 1'b0;
        end else begin
            cs_d <= cs_s;
            sk_d <= sk_s;
            if (!cs_s) begin
                st <= ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: if (cs_rise) st <= busy ? ST_STAT : ST_START;
                    ST_START: if (sk_rise && di_s) begin
                        st  <= ST_CMD;
                        cnt <= '0;
                    end
                    ST_CMD: if (sk_rise) begin
                        cmd_q <= cmd_nx;
                        cnt   <= cnt + 1'b1;
                        if (cmd_last) begin
                            cnt <= '0;
                            st  <= ST_DONE;
                            unique case (cmd_nx.opc)
                                OP_READ: begin
                                    st     <= ST_READ;
                                    shreg  <= rd_word;
                                    dout_q <= 1'b0;
                                end
                                OP_WRITE: st <= ST_DATA;
                                OP_ERASE: st <= ST_DONE;
                                OP_EXT: begin
                                    unique case (ext_of(cmd_nx.addr))
                                        EX_OPEN:  wen_q <= 1'b1;
                                        EX_LOCK:  wen_q <= 1'b0;
                                        EX_FILL:  st    <= ST_DATA;
                                        EX_CLEAR: st    <= ST_DONE;
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_READ: if (sk_rise) begin
                        if (cnt == CNT_W'(WORD_W)) begin
                            st <= ST_DONE;
                        end else begin
                            dout_q <= shreg[WORD_W-1];
                            shreg  <= {shreg[WORD_W-2:0], 1'b0};
                            cnt    <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: if (sk_rise) begin
                        shreg <= data_nx;
                        cnt   <= cnt + 1'b1;
                        if (data_last) st <= ST_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sdo_oe_o = (st == ST_READ) || (st == ST_STAT);
    assign sdo_o    = (st == ST_STAT) ? !busy : dout_q;

    // R10: output released one clock after chip select drops
    a_r10_oe_off: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> !sdo_oe_o);
    // R3: a program cycle only begins while permission is on
    a_r3_prog_needs_wen: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wen_q));
    // R9: a select edge with no cycle running never enters status
    a_r9_no_late_status: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && cs_rise && !busy) |=> st != ST_STAT);
    // R2: read data holds between serial-clock rising edges
    a_r2_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READ && $past(st == ST_READ) && !$past(sk_rise)) |-> $stable(sdo_o));
endmodule

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;
    localparam int PCYC = 300;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe;

    always #4 clk = ~clk;

    mw_eeprom #(.PROG_CYC(PCYC), .SYNC_STAGES(2)) u_mw_eeprom (
        .clk(clk), .rst(rst), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    typedef struct {
        logic  v;
        logic  oe;
        string tag;
    } exp_t;

    exp_t q[$];
    event smp;
    int total = 0;
    int bad = 0;
    bit done = 0;

    initial begin
        forever begin
            @(smp);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (sdo_oe !== e.oe || (e.oe && sdo !== e.v)) begin
                    bad++;
                    $display("FAIL %s: got oe=%b d=%b expected oe=%b d=%b",
                             e.tag, sdo_oe, sdo, e.oe, e.v);
                end
            end
        end
    end

    task automatic expect_out(input logic v, input logic oe, input string tag);
        exp_t e;
        e.v = v; e.oe = oe; e.tag = tag;
        q.push_back(e);
        -> smp;
        @(negedge clk);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_bit(input logic b);
        sclk = 1'b0; sdi = b; wait_clk(HALF);
        sclk = 1'b1;          wait_clk(HALF);
    endtask

    task automatic cs_on();
        sclk = 1'b0; sel = 1'b1; wait_clk(HALF);
    endtask

    task automatic cs_off();
        sclk = 1'b0; sel = 1'b0; sdi = 1'b0; wait_clk(HALF);
    endtask

    task automatic send_cmd(input logic [1:0] opc, input logic [5:0] a);
        sk_bit(1'b1);
        for (int i = 1; i >= 0; i--) sk_bit(opc[i]);
        for (int i = 5; i >= 0; i--) sk_bit(a[i]);
    endtask

    task automatic send_word(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) sk_bit(d[i]);
    endtask

    task automatic read_check(input logic [5:0] a, input logic [15:0] exp, input string tag);
        cs_on();
        send_cmd(2'b10, a);
        expect_out(1'b0, 1'b1, {tag, " R2 dummy zero"});
        for (int i = 15; i >= 0; i--) begin
            sk_bit(1'b0);
            expect_out(exp[i], 1'b1, tag);
        end
        cs_off();
        expect_out(1'b0, 1'b0, "R10 oe low after select drop");
    endtask

    task automatic prog_word(input logic [1:0] opc, input logic [5:0] a, input logic [15:0] d);
        cs_on();
        send_cmd(opc, a);
        send_word(d);
        cs_off();
    endtask

    initial begin
        wait_clk(200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        expect_out(1'b0, 1'b0, "R10 oe low in reset");
        rst = 1'b0;
        wait_clk(5);
        expect_out(1'b0, 1'b0, "R10 oe low after reset");

        read_check(6'd5, 16'hFFFF, "R10 reset content / R4 read while locked");

        prog_word(2'b01, 6'd5, 16'h1234);
        cs_on();
        expect_out(1'b0, 1'b0, "R3 no busy status while locked");
        cs_off();
        read_check(6'd5, 16'hFFFF, "R3 locked write ignored");

        // R1: leading zeros before start bit, then enable form 00 11xxxx
        cs_on();
        sk_bit(1'b0); sk_bit(1'b0);
        send_cmd(2'b00, 6'b110000);
        cs_off();

        prog_word(2'b01, 6'd5, 16'hA5C3);
        cs_on();
        expect_out(1'b0, 1'b1, "R8 busy shows zero");
        wait_clk(PCYC + 20);
        expect_out(1'b1, 1'b1, "R8 ready shows one");
        cs_off();
        expect_out(1'b0, 1'b0, "R8 status released");
        read_check(6'd5, 16'hA5C3, "R5 write MSB first / R1 framing");

        prog_word(2'b01, 6'd63, 16'h0001);
        wait_clk(PCYC + 20);
        cs_on();
        expect_out(1'b0, 1'b0, "R9 no status after cycle end");
        cs_off();
        read_check(6'd63, 16'h0001, "R5 write top address");

        cs_on(); send_cmd(2'b11, 6'd5); cs_off();
        wait_clk(PCYC + 20);
        read_check(6'd5, 16'hFFFF, "R6 erase word");
        read_check(6'd63, 16'h0001, "R6 erase leaves other word");

        prog_word(2'b00, 6'b010000, 16'h5A0F);
        wait_clk(PCYC + 20);
        read_check(6'd0,  16'h5A0F, "R7 write-all word 0");
        read_check(6'd33, 16'h5A0F, "R7 write-all word 33");
        read_check(6'd63, 16'h5A0F, "R7 write-all word 63");

        cs_on(); send_cmd(2'b00, 6'b100000); cs_off();
        cs_on();
        expect_out(1'b0, 1'b1, "R6 erase-all busy status");
        cs_off();
        wait_clk(PCYC + 20);
        read_check(6'd7, 16'hFFFF, "R6 erase-all");

        prog_word(2'b01, 6'd9, 16'h00FF);
        wait_clk(PCYC + 20);
        cs_on(); send_cmd(2'b00, 6'b000000); cs_off();
        prog_word(2'b01, 6'd9, 16'h1111);
        cs_on();
        expect_out(1'b0, 1'b0, "R4 no cycle after disable");
        cs_off();
        read_check(6'd9, 16'h00FF, "R4 disable blocks write, read still works");

        wait_clk(4);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule